// File: doc/BRIEF.md
# Log-Structured Page-Mapped Flash Translator

This block turns logical page numbers into physical page locations for a small flash array held in on-chip storage. It never overwrites a programmed page. Every host write goes to the next free page of the block that is being filled. The block then points the logical entry at that new page and retires the page that held the previous version. A host read follows the map to the physical page and returns its contents.

Each physical page has a state: erased, holding live data, or holding stale data. A programmed page also keeps the logical page number it was written for, so that a reclaim unit can later decide which pages are still live. The reclaim unit reads state and tag through a combinational probe port. It supplies erased blocks through a simple grant handshake. When the current block is full, the translator raises a block request and holds the host off until a grant arrives.

Top module: `lpt_translator`

## Requirements
- R1: After a synchronous active-low reset, every physical page probes as erased (state code 0), and a read of any logical page reports it as unmapped.
- R2: Writes fill block 0 first. Within the active block, pages are programmed strictly in ascending order, so the physical page number is active_block*4 + slot, and slot rises from 0 to 3.
- R3: A read of a mapped logical page returns the data of its latest write, with the unmapped flag low and the mapped physical page number on rsp_ppn.
- R4: When a logical page is rewritten, its previous physical page probes as stale (state code 2) and the new page probes as live (state code 1).
- R5: A programmed page probes with a tag equal to the logical page number written to it.
- R6: A read of a logical page that was never written returns data 8'hFF, the unmapped flag high and rsp_ppn 0.
- R7: Once the fourth page of the active block has been programmed, blk_req goes high and req_ready goes low. Host requests get no response until a grant is taken.
- R8: A grant taken while blk_req is high makes the granted block active from its slot 0. All its pages probe as erased, and the next write lands on granted_block*4.
- R9: A response (rsp_valid high for one cycle) appears on the clock edge after each accepted request and at no other time. For a write, rsp_data echoes the written data and rsp_ppn gives the page used. req_write high means write and low means read.
- R10: A page is never programmed unless it is in the erased state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpn | input | 4 | Logical page number |
| req_data | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_ppn | output | 5 | Physical page used or read |
| rsp_data | output | 8 | Read data, or echoed write data |
| rsp_unmapped | output | 1 | Read of a never-written logical page |
| blk_req | output | 1 | Active block full, erased block wanted |
| blk_grant_valid | input | 1 | Reclaim unit offers an erased block |
| blk_grant_id | input | 3 | Index of the offered block |
| probe_ppn | input | 5 | Physical page to inspect |
| probe_state | output | 2 | State of the probed page (0 erased, 1 live, 2 stale) |
| probe_tag | output | 4 | Logical tag stored with the probed page |

## Verification
Two kinds of internal fault show up at the ports in different ways. A corrupted map entry or data array shows on the next read of that logical page: the wrong rsp_data or rsp_ppn appears one cycle after the read is accepted. A wrong write pointer shows on the very next write response as a physical page out of sequence. A page state that is not updated is invisible to the host. It is caught through the probe port right after the write that should have changed it. The fill and grant sequence is checked on the cycle after the fourth program and again on the cycle after the grant.

// File: rtl/lpt_pkg.sv
// Shared types for the log-structured page translator.
// Assumes two bits are enough to encode a page state.
package lpt_pkg;
    typedef enum logic [1:0] {
        PG_ERASED  = 2'd0,
        PG_VALID   = 2'd1,
        PG_INVALID = 2'd2
    } pg_state_e;
endpackage

// File: rtl/lpt_map.sv
// Logical-to-physical map: one entry and one mapped bit per logical page.
// Assumes at most one update per cycle. The lookup is combinational, so a
// read accepted in the cycle after a write sees that write.
module lpt_map #(
    parameter int NUM_LPAGES = 16,
    parameter int PPN_W      = 5,
    localparam int LPN_W     = $clog2(NUM_LPAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LPN_W-1:0] look_lpn,
    output logic [PPN_W-1:0] look_ppn,
    output logic             look_mapped,
    input  logic             upd_en,
    input  logic [LPN_W-1:0] upd_lpn,
    input  logic [PPN_W-1:0] upd_ppn
);
    logic [PPN_W-1:0] ppn_q    [NUM_LPAGES];
    logic             mapped_q [NUM_LPAGES];

    // Purpose: clear every entry on reset; record the new location on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LPAGES; i++) begin
                ppn_q[i]    <= '0;
                mapped_q[i] <= 1'b0;
            end
        end else if (upd_en) begin
            ppn_q[upd_lpn]    <= upd_ppn;
            mapped_q[upd_lpn] <= 1'b1;
        end
    end

    // Purpose: combinational lookup for the current request.
    always_comb begin
        look_ppn    = ppn_q[look_lpn];
        look_mapped = mapped_q[look_lpn];
    end

    // R3: an updated entry reads back mapped on the next cycle
    p_map_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> mapped_q[$past(upd_lpn)]);
endmodule

// File: rtl/lpt_page_store.sv
// Physical page store: data, out-of-band logical tag and state per page.
// Assumes the caller programs only erased pages, retires only live pages,
// and never erases a block in the same cycle as a program or a retire.
module lpt_page_store
    import lpt_pkg::*;
#(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int DATA_W          = 8,
    parameter int LPN_W           = 4,
    localparam int NUM_PAGES      = NUM_BLOCKS * PAGES_PER_BLOCK,
    localparam int PPN_W          = $clog2(NUM_PAGES),
    localparam int BLK_W          = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [PPN_W-1:0]  prog_ppn,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [LPN_W-1:0]  prog_tag,
    input  logic              inval_en,
    input  logic [PPN_W-1:0]  inval_ppn,
    input  logic              erase_en,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [PPN_W-1:0]  rd_ppn,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PPN_W-1:0]  probe_ppn,
    output pg_state_e         probe_state,
    output logic [LPN_W-1:0]  probe_tag
);
    logic [DATA_W-1:0] data_q  [NUM_PAGES];
    logic [LPN_W-1:0]  tag_q   [NUM_PAGES];
    pg_state_e         state_q [NUM_PAGES];

    // Purpose: payload and tag arrays written on program; no reset needed.
    always_ff @(posedge clk) begin
        if (prog_en) begin
            data_q[prog_ppn] <= prog_data;
            tag_q[prog_ppn]  <= prog_tag;
        end
    end

    // Per-page state flop, generated once per physical page.
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        localparam int BLK_OF_PAGE = g / PAGES_PER_BLOCK;
        // Purpose: reset to erased; erase, program or retire moves the state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[g] <= PG_ERASED;
            end else if (erase_en && (32'(erase_blk) == BLK_OF_PAGE)) begin
                state_q[g] <= PG_ERASED;
            end else if (prog_en && (32'(prog_ppn) == g)) begin
                state_q[g] <= PG_VALID;
            end else if (inval_en && (32'(inval_ppn) == g)) begin
                state_q[g] <= PG_INVALID;
            end
        end
    end

    // Purpose: combinational read and probe paths.
    always_comb begin
        rd_data     = data_q[rd_ppn];
        probe_state = state_q[probe_ppn];
        probe_tag   = tag_q[probe_ppn];
    end

    // R10: programming is only ever directed at an erased page
    p_prog_erased_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (state_q[prog_ppn] == PG_ERASED));
    // R4: a retired page is stale on the following cycle
    p_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inval_en |=> (state_q[$past(inval_ppn)] == PG_INVALID));
    // R4: only live pages are retired
    p_retire_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inval_en |-> (state_q[inval_ppn] == PG_VALID));
endmodule

// File: rtl/lpt_log_alloc.sv
// Append-log allocator: holds the active block and the next free slot.
// Assumes PAGES_PER_BLOCK is a power of two, so a page number is the
// concatenation of block index and slot. Raises a block request when full.
module lpt_log_alloc #(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 4,
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int OFF_W          = $clog2(PAGES_PER_BLOCK),
    localparam int PPN_W          = BLK_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_page,
    output logic [PPN_W-1:0] next_ppn,
    output logic             full,
    output logic             blk_req,
    input  logic             grant_valid,
    input  logic [BLK_W-1:0] grant_id,
    output logic             grant_take
);
    localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGES_PER_BLOCK - 1);

    logic [BLK_W-1:0] act_blk_q;
    logic [OFF_W-1:0] slot_q;
    logic             full_q;

    // Purpose: advance the slot on each program; switch block on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_blk_q <= '0;
            slot_q    <= '0;
            full_q    <= 1'b0;
        end else if (grant_take) begin
            act_blk_q <= grant_id;
            slot_q    <= '0;
            full_q    <= 1'b0;
        end else if (take_page) begin
            if (slot_q == LAST_SLOT) begin
                full_q <= 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Purpose: expose the next page and the handshake flags.
    always_comb begin
        next_ppn   = {act_blk_q, slot_q};
        full       = full_q;
        blk_req    = full_q;
        grant_take = full_q && grant_valid;
    end

    // R2: pages inside a block are taken in strictly ascending order
    p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_page && (slot_q != LAST_SLOT)) |=> (slot_q == $past(slot_q) + 1'b1));
    // R7: taking the last slot makes the block full
    p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_page && (slot_q == LAST_SLOT)) |=> full_q);
    // R10: no page is taken while the block is full
    p_no_take_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !take_page);
    // R8: a taken grant reopens a block at slot zero
    p_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_take |=> (!full_q && (slot_q == '0)));
endmodule

// File: rtl/lpt_translator.sv
// Top of the log-structured page translator. It accepts one host request
// per cycle. A write goes to the next free page in the append log; a read
// follows the map. The response is registered one cycle after acceptance.
// Assumes the reclaim unit only grants blocks it has already erased.
module lpt_translator
    import lpt_pkg::*;
#(
    parameter int NUM_BLOCKS      = 8,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int NUM_LPAGES      = 16,
    parameter int DATA_W          = 8,
    localparam int NUM_PAGES      = NUM_BLOCKS * PAGES_PER_BLOCK,
    localparam int PPN_W          = $clog2(NUM_PAGES),
    localparam int BLK_W          = $clog2(NUM_BLOCKS),
    localparam int LPN_W          = $clog2(NUM_LPAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LPN_W-1:0]  req_lpn,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_unmapped,
    output logic              blk_req,
    input  logic              blk_grant_valid,
    input  logic [BLK_W-1:0]  blk_grant_id,
    input  logic [PPN_W-1:0]  probe_ppn,
    output logic [1:0]        probe_state,
    output logic [LPN_W-1:0]  probe_tag
);
    logic              accept, do_write;
    logic              full, grant_take;
    logic [PPN_W-1:0]  next_ppn, map_ppn, rd_ppn;
    logic              map_mapped;
    logic [DATA_W-1:0] store_data;
    pg_state_e         probe_state_e;

    // Purpose: host handshake; the host is held off while no page is free.
    always_comb begin
        req_ready = !full;
        accept    = req_valid && req_ready;
        do_write  = accept && req_write;
        rd_ppn    = map_ppn;
    end

    lpt_map #(.NUM_LPAGES(NUM_LPAGES), .PPN_W(PPN_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .look_lpn(req_lpn), .look_ppn(map_ppn), .look_mapped(map_mapped),
        .upd_en(do_write), .upd_lpn(req_lpn), .upd_ppn(next_ppn)
    );

    lpt_log_alloc #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_alloc (
        .clk(clk), .rst_n(rst_n),
        .take_page(do_write), .next_ppn(next_ppn), .full(full), .blk_req(blk_req),
        .grant_valid(blk_grant_valid), .grant_id(blk_grant_id), .grant_take(grant_take)
    );

    lpt_page_store #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .DATA_W(DATA_W), .LPN_W(LPN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .prog_en(do_write), .prog_ppn(next_ppn), .prog_data(req_data), .prog_tag(req_lpn),
        .inval_en(do_write && map_mapped), .inval_ppn(map_ppn),
        .erase_en(grant_take), .erase_blk(blk_grant_id),
        .rd_ppn(rd_ppn), .rd_data(store_data),
        .probe_ppn(probe_ppn), .probe_state(probe_state_e), .probe_tag(probe_tag)
    );

    // Purpose: present the probe state as a plain code.
    always_comb probe_state = probe_state_e;

    // Purpose: register the response for the request accepted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_ppn      <= '0;
            rsp_data     <= '0;
            rsp_unmapped <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                if (req_write) begin
                    rsp_ppn      <= next_ppn;
                    rsp_data     <= req_data;
                    rsp_unmapped <= 1'b0;
                end else if (map_mapped) begin
                    rsp_ppn      <= map_ppn;
                    rsp_data     <= store_data;
                    rsp_unmapped <= 1'b0;
                end else begin
                    rsp_ppn      <= '0;
                    rsp_data     <= '1;
                    rsp_unmapped <= 1'b1;
                end
            end
        end
    end

    // R9: every accepted request gets a response on the next cycle
    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    // R9: no response without an accepted request
    p_rsp_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);
    // R7: a block request persists until a grant is taken
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && !blk_grant_valid) |=> blk_req);
    // R6: unmapped responses carry all-ones data
    p_unmapped_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_unmapped) |-> (rsp_data == '1));
endmodule

// File: tb/lpt_translator_bench.sv
`timescale 1ns/1ps
module lpt_translator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [3:0] req_lpn = '0;
    logic [7:0] req_data = '0;
    logic       req_ready, rsp_valid, rsp_unmapped, blk_req;
    logic [4:0] rsp_ppn;
    logic [7:0] rsp_data;
    logic       blk_grant_valid = 1'b0;
    logic [2:0] blk_grant_id = '0;
    logic [4:0] probe_ppn = '0;
    logic [1:0] probe_state;
    logic [3:0] probe_tag;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lpt_translator u_lpt_translator (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_lpn(req_lpn), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_data(rsp_data),
        .rsp_unmapped(rsp_unmapped), .blk_req(blk_req),
        .blk_grant_valid(blk_grant_valid), .blk_grant_id(blk_grant_id),
        .probe_ppn(probe_ppn), .probe_state(probe_state), .probe_tag(probe_tag)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] lpn;
        logic [7:0] data;
        logic [4:0] e_ppn;
        logic [7:0] e_data;
        logic       e_unm;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd5,  8'hA1, 5'd0, 8'hA1, 1'b0},   // R2 first page
        '{1'b0, 4'd5,  8'h00, 5'd0, 8'hA1, 1'b0},   // R3
        '{1'b0, 4'd9,  8'h00, 5'd0, 8'hFF, 1'b1},   // R6
        '{1'b1, 4'd2,  8'hB2, 5'd1, 8'hB2, 1'b0},   // R2
        '{1'b1, 4'd5,  8'hC3, 5'd2, 8'hC3, 1'b0},   // R2 rewrite
        '{1'b0, 4'd5,  8'h00, 5'd2, 8'hC3, 1'b0},   // R3 latest copy
        '{1'b0, 4'd2,  8'h00, 5'd1, 8'hB2, 1'b0},   // R3
        '{1'b1, 4'd15, 8'h5E, 5'd3, 8'h5E, 1'b0}    // R2 last slot
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request; response is sampled at the negedge after the accept edge.
    task automatic xact(input logic wr, input logic [3:0] lpn, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_lpn = lpn; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic probe(input logic [4:0] ppn);
        probe_ppn = ppn;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all pages erased, outputs idle
        for (int p = 0; p < 32; p++) begin
            probe(5'(p));
            chk("R1 page erased", probe_state, 0);
        end
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 no block request", blk_req, 0);
        chk("R9 idle rsp_valid", rsp_valid, 0);
        xact(1'b0, 4'd0, 8'h00);
        chk("R1 read unmapped", rsp_unmapped, 1);
        chk("R9 rsp after accept", rsp_valid, 1);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            xact(VEC[i].wr, VEC[i].lpn, VEC[i].data);
            chk("R9 rsp_valid", rsp_valid, 1);
            chk("R2/R3 rsp_ppn", rsp_ppn, VEC[i].e_ppn);
            chk("R3/R6 rsp_data", rsp_data, VEC[i].e_data);
            chk("R6 rsp_unmapped", rsp_unmapped, VEC[i].e_unm);
        end
        @(negedge clk);
        chk("R9 single-cycle rsp", rsp_valid, 0);

        // R4/R5: page states and tags
        probe(5'd0); chk("R4 old copy stale", probe_state, 2);
        probe(5'd2); chk("R4 new copy live", probe_state, 1);
        probe(5'd2); chk("R5 tag of page 2", probe_tag, 5);
        probe(5'd1); chk("R5 tag of page 1", probe_tag, 2);
        probe(5'd3); chk("R5 tag of page 3", probe_tag, 15);
        probe(5'd4); chk("R1 untouched page erased", probe_state, 0);

        // R7: full block stalls the host
        chk("R7 blk_req high", blk_req, 1);
        chk("R7 ready low", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b0; req_lpn = 4'd5;
        repeat (3) begin
            @(negedge clk);
            chk("R7 no response while stalled", rsp_valid, 0);
            chk("R7 still stalled", req_ready, 0);
        end
        req_valid = 1'b0;

        // R8: grant block 6
        @(negedge clk);
        blk_grant_valid = 1'b1; blk_grant_id = 3'd6;
        @(posedge clk);
        @(negedge clk);
        blk_grant_valid = 1'b0;
        chk("R8 ready after grant", req_ready, 1);
        chk("R8 request dropped", blk_req, 0);
        for (int p = 24; p < 28; p++) begin
            probe(5'(p));
            chk("R8 granted block erased", probe_state, 0);
        end
        xact(1'b1, 4'd2, 8'h77);
        chk("R8 write lands at slot 0", rsp_ppn, 24);
        probe(5'd1);  chk("R4 previous page of lpn 2 stale", probe_state, 2);
        probe(5'd24); chk("R4 new page live", probe_state, 1);
        xact(1'b0, 4'd2, 8'h00);
        chk("R3 read after block switch", rsp_data, 8'h77);
        xact(1'b0, 4'd15, 8'h00);
        chk("R3 old block data kept", rsp_data, 8'h5E);
        chk("R3 old block ppn", rsp_ppn, 3);
        xact(1'b1, 4'd9, 8'h3C);
        chk("R2 ascending in new block", rsp_ppn, 25);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule